// File: doc/BRIEF.md
# PCI Bus Master Read Engine

This block is the read half of a 32-bit PCI bus master. A local requester hands it a start byte address, a word count, a target kind (setup block, descriptor area or transmit buffer) and three configuration bits. The engine asks for the bus with REQ#, waits for GNT#, drives one address phase carrying a command picked from the target kind and the configuration, and then runs one or more data phases. It returns each 32-bit word to the requester through a one-cycle valid strobe. When the request is finished it pulses `done`, together with `err` if no target claimed the cycle.

Bursting needs two enables. A global burst enable turns bursting on, and descriptor reads need a second bit that selects the burst-capable descriptor layout. When bursting is off, every word goes out as its own single-data-phase transaction, each with its own REQ#/GNT# handshake. A bus grant always carries exactly one transaction. The engine drives the bus pins as separate output, output-enable and input signals, and the pad ring combines them.

Top module: `pci_rd_master`

## Requirements
- R1: Reads of kind 2'b00 (setup block) and kind 2'b01 (descriptor area) drive command 4'b0110 on C/BE# in the address phase, and so does every single-phase transaction of any kind.
- R2: A burst transaction of kind 2'b10 (transmit buffer) drives 4'b1110 when `cfg_multi_cmd` is 0 and 4'b1100 when it is 1.
- R3: With `cfg_burst_en` low, a request of N words produces N transactions, each with one data phase at consecutive word addresses. With it high, a request of kind 00 or 10 produces one transaction of N data phases.
- R4: A kind 01 request bursts only when both `cfg_burst_en` and `cfg_desc_burst` are high. Otherwise it is issued as single-phase transactions.
- R5: In the address phase AD[1:0] is 2'b00 and AD[31:2] holds the word address. In every data phase C/BE# is 4'b0000.
- R6: REQ# is high during every address phase, and an address phase starts only after GNT# was sampled low. Each grant carries one transaction.
- R7: IRDY# goes low in the clock directly after the address phase, so a target that asserts DEVSEL# and TRDY# at once completes a zero-wait-state phase.
- R8: FRAME# is high during the final data phase of a transaction and low during every earlier data phase. After the final phase completes, FRAME# and IRDY# are both high.
- R9: While TRDY# is high the engine holds IRDY# low and FRAME# unchanged. A word is taken, and presented on `rd_data` with `rd_valid` one clock later, only on clocks where IRDY#, TRDY# and DEVSEL# are all sampled low.
- R10: PAR is driven, with its enable, in the clock after each address phase as the even parity of that phase's AD[31:0] and C/BE#[3:0].
- R11: If DEVSEL# is not sampled low within 4 data clocks after the address phase, the engine ends the transaction, delivers no data, drops the rest of the request and pulses `done` and `err` together.
- R12: In the first word of a request, byte lanes below the start offset `req_addr[1:0]` are returned as 8'h00. All other lanes carry the received bytes.
- R13: A request with `req_words` equal to zero is ignored: `busy` stays low, REQ# stays high and no `done` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a read request (taken when idle) |
| req_addr | input | 32 | Start byte address |
| req_words | input | 8 | Number of 32-bit words to read |
| req_kind | input | 2 | 00 setup block, 01 descriptor, 10 transmit buffer |
| cfg_burst_en | input | 1 | Global burst read enable |
| cfg_desc_burst | input | 1 | Burst-capable descriptor layout selected |
| cfg_multi_cmd | input | 1 | Transmit-buffer bursts use Memory Read Multiple |
| busy | output | 1 | Request in progress |
| rd_valid | output | 1 | `rd_data` holds a received word |
| rd_data | output | 32 | Received word, unrequested lanes zeroed |
| done | output | 1 | One-cycle pulse at request end |
| err | output | 1 | Master abort, valid with `done` |
| pci_req_n_o | output | 1 | Bus request, active low |
| pci_gnt_n_i | input | 1 | Bus grant, active low |
| frame_n_o | output | 1 | FRAME# drive value |
| irdy_n_o | output | 1 | IRDY# drive value |
| ctl_oe | output | 1 | Output enable for FRAME# and IRDY# |
| ad_o | output | 32 | AD drive value |
| ad_oe | output | 1 | AD output enable |
| ad_i | input | 32 | AD sampled value |
| cbe_o | output | 4 | C/BE# drive value |
| cbe_oe | output | 1 | C/BE# output enable |
| par_o | output | 1 | PAR drive value |
| par_oe | output | 1 | PAR output enable |
| devsel_n_i | input | 1 | DEVSEL# from target |
| trdy_n_i | input | 1 | TRDY# from target |

## Verification
The assertions assume that the arbiter holds GNT# low until the engine's address phase appears, and that the bus is idle whenever GNT# is given, so no other master's FRAME# or IRDY# overlaps. They also assume that a target, once DEVSEL# is low, keeps it low until the transaction ends, and that TRDY# low is only meaningful with DEVSEL# low. The bench's target model follows these rules. It grants one clock after REQ#, removes the grant at the address phase and asserts DEVSEL# after 0 to 3 data clocks. It then either holds DEVSEL# for the whole transaction or never drives it, and it inserts a fixed number of TRDY# wait clocks before each data phase.

// File: rtl/pci_rd_pkg.sv
package pci_rd_pkg;

   typedef enum logic [1:0] {
      KIND_SETUP = 2'b00,
      KIND_DESC  = 2'b01,
      KIND_TXBUF = 2'b10,
      KIND_RSVD  = 2'b11
   } rd_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ,
      ST_ADDR,
      ST_DATA,
      ST_END
   } rd_state_e;

   localparam logic [3:0] CMD_MEM_RD      = 4'b0110;
   localparam logic [3:0] CMD_MEM_RD_LINE = 4'b1110;
   localparam logic [3:0] CMD_MEM_RD_MULT = 4'b1100;
   localparam logic [3:0] CBE_ALL_LANES   = 4'b0000;

endpackage

// File: rtl/pci_rd_cmdsel.sv
module pci_rd_cmdsel
   import pci_rd_pkg::*;
#(
   parameter bit BURST_SUPPORT = 1'b1
) (
   input  rd_kind_e   kind,
   input  logic       burst_en,
   input  logic       desc_burst,
   input  logic       multi_cmd,
   output logic [3:0] cmd,
   output logic       burst
);

   generate
      if (BURST_SUPPORT) begin : g_burst
         // descriptor fetches need the second enable as well
         assign burst = burst_en && ((kind != KIND_DESC) || desc_burst);
      end else begin : g_single
         logic unused_cfg;
         assign unused_cfg = burst_en ^ desc_burst;
         assign burst = 1'b0;
      end
   endgenerate

   always_comb begin
      if (burst && (kind == KIND_TXBUF))
         cmd = multi_cmd ? CMD_MEM_RD_MULT : CMD_MEM_RD_LINE;
      else
         cmd = CMD_MEM_RD;
   end

endmodule

// File: rtl/pci_rd_parity.sv
module pci_rd_parity #(
   parameter int AD_W  = 32,
   parameter int CBE_W = AD_W / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [AD_W-1:0]  ad,
   input  logic [CBE_W-1:0] cbe,
   output logic             par,
   output logic             par_oe
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par    <= 1'b0;
         par_oe <= 1'b0;
      end else begin
         par_oe <= load;
         if (load)
            par <= ^{ad, cbe};
      end
   end

endmodule

// File: rtl/pci_rd_lanes.sv
module pci_rd_lanes #(
   parameter int AD_W  = 32,
   parameter int LANES = AD_W / 8,
   parameter int OFF_W = $clog2(LANES)
) (
   input  logic             first,
   input  logic [OFF_W-1:0] offset,
   input  logic [AD_W-1:0]  din,
   output logic [AD_W-1:0]  dout
);

   generate
      for (genvar b = 0; b < LANES; b++) begin : g_lane
         assign dout[8*b +: 8] = (first && (OFF_W'(b) < offset)) ? 8'h00 : din[8*b +: 8];
      end
   endgenerate

endmodule

// File: rtl/pci_rd_master.sv
module pci_rd_master
   import pci_rd_pkg::*;
#(
   parameter int AD_W          = 32,
   parameter int CNT_W         = 8,
   parameter int DEVSEL_TO     = 4,
   parameter bit BURST_SUPPORT = 1'b1,
   localparam int CBE_W = AD_W / 8,
   localparam int OFF_W = $clog2(CBE_W),
   localparam int WA_W  = AD_W - OFF_W,
   localparam int TO_W  = $clog2(DEVSEL_TO + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [AD_W-1:0]  req_addr,
   input  logic [CNT_W-1:0] req_words,
   input  logic [1:0]       req_kind,
   input  logic             cfg_burst_en,
   input  logic             cfg_desc_burst,
   input  logic             cfg_multi_cmd,
   output logic             busy,
   output logic             rd_valid,
   output logic [AD_W-1:0]  rd_data,
   output logic             done,
   output logic             err,
   output logic             pci_req_n_o,
   input  logic             pci_gnt_n_i,
   output logic             frame_n_o,
   output logic             irdy_n_o,
   output logic             ctl_oe,
   output logic [AD_W-1:0]  ad_o,
   output logic             ad_oe,
   input  logic [AD_W-1:0]  ad_i,
   output logic [CBE_W-1:0] cbe_o,
   output logic             cbe_oe,
   output logic             par_o,
   output logic             par_oe,
   input  logic             devsel_n_i,
   input  logic             trdy_n_i
);

   generate
      if (AD_W != 32) begin : g_bad_width
         $error("pci_rd_master: AD_W must be 32");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("pci_rd_master: CNT_W must be at least 1");
      end
      if (DEVSEL_TO < 1) begin : g_bad_to
         $error("pci_rd_master: DEVSEL_TO must be at least 1");
      end
   endgenerate

   localparam logic [CNT_W-1:0] ONE_WORD = CNT_W'(1);

   rd_state_e        st;
   rd_kind_e         kind_r;
   logic             ben_r, dburst_r, multi_r;
   logic [WA_W-1:0]  waddr;
   logic [OFF_W-1:0] off_r;
   logic             first_r;
   logic [CNT_W-1:0] left_all, left_txn;
   logic             dev_seen, abort_r;
   logic [TO_W-1:0]  tocnt;

   logic [3:0]       cmd;
   logic             burst;
   logic [AD_W-1:0]  lane_data;
   logic             last_ph, xfer;

   pci_rd_cmdsel #(.BURST_SUPPORT(BURST_SUPPORT)) u_cmd (
      .kind       (kind_r),
      .burst_en   (ben_r),
      .desc_burst (dburst_r),
      .multi_cmd  (multi_r),
      .cmd        (cmd),
      .burst      (burst)
   );

   pci_rd_lanes #(.AD_W(AD_W)) u_lanes (
      .first  (first_r),
      .offset (off_r),
      .din    (ad_i),
      .dout   (lane_data)
   );

   pci_rd_parity #(.AD_W(AD_W), .CBE_W(CBE_W)) u_par (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (st == ST_ADDR),
      .ad     (ad_o),
      .cbe    (cbe_o),
      .par    (par_o),
      .par_oe (par_oe)
   );

   assign last_ph = (left_txn == ONE_WORD);
   assign xfer    = (st == ST_DATA) && !trdy_n_i && !devsel_n_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         kind_r   <= KIND_SETUP;
         ben_r    <= 1'b0;
         dburst_r <= 1'b0;
         multi_r  <= 1'b0;
         waddr    <= '0;
         off_r    <= '0;
         first_r  <= 1'b0;
         left_all <= '0;
         left_txn <= '0;
         dev_seen <= 1'b0;
         abort_r  <= 1'b0;
         tocnt    <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
         done     <= 1'b0;
         err      <= 1'b0;
      end else begin
         rd_valid <= 1'b0;
         done     <= 1'b0;
         err      <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (req_valid && (req_words != '0)) begin
                  kind_r   <= rd_kind_e'(req_kind);
                  ben_r    <= cfg_burst_en;
                  dburst_r <= cfg_desc_burst;
                  multi_r  <= cfg_multi_cmd;
                  waddr    <= req_addr[AD_W-1:OFF_W];
                  off_r    <= req_addr[OFF_W-1:0];
                  first_r  <= 1'b1;
                  left_all <= req_words;
                  st       <= ST_REQ;
               end
            end
            ST_REQ: begin
               if (!pci_gnt_n_i) begin
                  left_txn <= burst ? left_all : ONE_WORD;
                  st       <= ST_ADDR;
               end
            end
            ST_ADDR: begin
               tocnt    <= '0;
               dev_seen <= 1'b0;
               abort_r  <= 1'b0;
               st       <= ST_DATA;
            end
            ST_DATA: begin
               if (!devsel_n_i)
                  dev_seen <= 1'b1;
               if (xfer) begin
                  rd_valid <= 1'b1;
                  rd_data  <= lane_data;
                  first_r  <= 1'b0;
                  waddr    <= waddr + 1'b1;
                  left_all <= left_all - 1'b1;
                  left_txn <= left_txn - 1'b1;
                  if (last_ph)
                     st <= ST_END;
               end else if (!dev_seen && devsel_n_i) begin
                  if (tocnt == TO_W'(DEVSEL_TO - 1)) begin
                     abort_r <= 1'b1;
                     st      <= ST_END;
                  end else begin
                     tocnt <= tocnt + 1'b1;
                  end
               end
            end
            ST_END: begin
               if (abort_r || (left_all == '0)) begin
                  done <= 1'b1;
                  err  <= abort_r;
                  st   <= ST_IDLE;
               end else begin
                  st <= ST_REQ;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      busy        = (st != ST_IDLE);
      pci_req_n_o = (st != ST_REQ);
      ctl_oe      = (st == ST_ADDR) || (st == ST_DATA) || (st == ST_END);
      frame_n_o   = !((st == ST_ADDR) || ((st == ST_DATA) && !last_ph));
      irdy_n_o    = (st != ST_DATA);
      ad_oe       = (st == ST_ADDR);
      ad_o        = {waddr, {OFF_W{1'b0}}};
      cbe_oe      = (st == ST_ADDR) || (st == ST_DATA);
      cbe_o       = (st == ST_ADDR) ? cmd : CBE_ALL_LANES;
   end

endmodule

// File: rtl/pci_rd_chk.sv
module pci_rd_chk #(
   parameter int AD_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            pci_req_n_o,
   input logic            pci_gnt_n_i,
   input logic            frame_n_o,
   input logic            irdy_n_o,
   input logic [AD_W-1:0] ad_o,
   input logic            ad_oe,
   input logic [3:0]      cbe_o,
   input logic            par_o,
   input logic            par_oe,
   input logic            trdy_n_i,
   input logic            devsel_n_i,
   input logic            rd_valid,
   input logic            done,
   input logic            err
);

   assert_cmd_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frame_n_o) |-> (cbe_o == 4'b0110 || cbe_o == 4'b1110 || cbe_o == 4'b1100));

   assert_linear_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frame_n_o) |-> (ad_oe && ad_o[1:0] == 2'b00));

   assert_all_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !irdy_n_o |-> (cbe_o == 4'b0000));

   assert_one_per_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frame_n_o) |-> (pci_req_n_o && $past(!pci_gnt_n_i)));

   assert_irdy_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frame_n_o) |=> !irdy_n_o);

   assert_final_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!irdy_n_o && frame_n_o && !trdy_n_i && !devsel_n_i) |=> (irdy_n_o && frame_n_o));

   assert_wait_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!irdy_n_o && trdy_n_i && !devsel_n_i) |=> (!irdy_n_o && $stable(frame_n_o)));

   assert_data_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(!irdy_n_o && !trdy_n_i && !devsel_n_i));

   assert_parity_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frame_n_o) |=> (par_oe && (par_o == (^$past(ad_o) ^ ^$past(cbe_o)))));

   assert_err_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

endmodule

bind pci_rd_master pci_rd_chk #(.AD_W(AD_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pci_req_n_o (pci_req_n_o),
   .pci_gnt_n_i (pci_gnt_n_i),
   .frame_n_o   (frame_n_o),
   .irdy_n_o    (irdy_n_o),
   .ad_o        (ad_o),
   .ad_oe       (ad_oe),
   .cbe_o       (cbe_o),
   .par_o       (par_o),
   .par_oe      (par_oe),
   .trdy_n_i    (trdy_n_i),
   .devsel_n_i  (devsel_n_i),
   .rd_valid    (rd_valid),
   .done        (done),
   .err         (err)
);

// File: tb/sim_pci_rd_master.sv
`timescale 1ns/1ps
module sim_pci_rd_master;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [7:0]  req_words = '0;
   logic [1:0]  req_kind = '0;
   logic        cfg_burst_en = 1'b0, cfg_desc_burst = 1'b0, cfg_multi_cmd = 1'b0;
   logic        busy, rd_valid, done, err;
   logic [31:0] rd_data;
   logic        pci_req_n_o, frame_n_o, irdy_n_o, ctl_oe, ad_oe, cbe_oe, par_o, par_oe;
   logic        pci_gnt_n_i = 1'b1, devsel_n_i = 1'b1, trdy_n_i = 1'b1;
   logic [31:0] ad_o, ad_i = '0;
   logic [3:0]  cbe_o;

   always #2 clk = ~clk;

   pci_rd_master u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_words(req_words), .req_kind(req_kind), .cfg_burst_en(cfg_burst_en),
      .cfg_desc_burst(cfg_desc_burst), .cfg_multi_cmd(cfg_multi_cmd),
      .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .err(err),
      .pci_req_n_o(pci_req_n_o), .pci_gnt_n_i(pci_gnt_n_i), .frame_n_o(frame_n_o),
      .irdy_n_o(irdy_n_o), .ctl_oe(ctl_oe), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i),
      .cbe_o(cbe_o), .cbe_oe(cbe_oe), .par_o(par_o), .par_oe(par_oe),
      .devsel_n_i(devsel_n_i), .trdy_n_i(trdy_n_i)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   typedef struct {
      logic [31:0] a;
      logic [3:0]  c;
      int          len;
   } txn_t;

   txn_t        txn_q[$];
   logic [31:0] exp_q[$];
   int          ntxn = 0;
   int          tgt_wait = 0, tgt_dly = 0;
   bit          tgt_nodev = 1'b0;

   function automatic logic [31:0] memw(input logic [31:0] a);
      return (a * 32'h0100_0193) ^ 32'h5AC3_1E0F;
   endfunction

   // arbiter and target model
   initial begin
      bit   act = 1'b0, drove = 1'b0, first_dc = 1'b0;
      int   idx = 0, dcnt = 0, wcnt = 0;
      logic par_exp = 1'b0;
      txn_t cur;
      cur = '{a: '0, c: '0, len: 0};
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            act = 1'b0; drove = 1'b0;
            pci_gnt_n_i = 1'b1; devsel_n_i = 1'b1; trdy_n_i = 1'b1;
         end else begin
            if (!pci_req_n_o) pci_gnt_n_i = 1'b0;
            else if (!frame_n_o) pci_gnt_n_i = 1'b1;
            if (act) begin
               if (drove && !trdy_n_i) begin
                  idx++;
                  wcnt = tgt_wait;
               end
               drove = 1'b0;
               if (first_dc) begin
                  chk(!irdy_n_o, "R7 irdy after address", {31'b0, irdy_n_o}, 32'h0);
                  chk(par_oe && (par_o == par_exp), "R10 parity", {30'b0, par_oe, par_o}, {30'b0, 1'b1, par_exp});
                  first_dc = 1'b0;
               end
               if (irdy_n_o && frame_n_o) begin
                  if (!tgt_nodev)
                     chk(idx == cur.len, "R8 phase count", idx, cur.len);
                  act = 1'b0;
                  devsel_n_i = 1'b1; trdy_n_i = 1'b1;
               end else if (!irdy_n_o) begin
                  chk(frame_n_o == (idx == cur.len - 1), "R8 frame level", {31'b0, frame_n_o}, {31'b0, (idx == cur.len - 1)});
                  chk(cbe_o == 4'b0000, "R5 byte enables", {28'b0, cbe_o}, 32'h0);
                  if (!tgt_nodev) begin
                     if (dcnt > 0) dcnt--;
                     else devsel_n_i = 1'b0;
                     if (!devsel_n_i) begin
                        if (wcnt > 0) begin
                           wcnt--;
                           trdy_n_i = 1'b1;
                        end else begin
                           trdy_n_i = 1'b0;
                           ad_i = memw(cur.a + 32'(4 * idx));
                           drove = 1'b1;
                        end
                     end
                  end
               end
            end else if (!frame_n_o && ad_oe && irdy_n_o) begin
               ntxn++;
               chk(pci_req_n_o, "R6 req released", {31'b0, pci_req_n_o}, 32'h1);
               if (txn_q.size() == 0) begin
                  chk(1'b0, "R3 unexpected transaction", ad_o, 32'h0);
                  cur = '{a: ad_o, c: cbe_o, len: 1};
               end else begin
                  cur = txn_q.pop_front();
                  chk(ad_o == cur.a, "R5 address", ad_o, cur.a);
                  chk(cbe_o == cur.c, "R1 R2 command", {28'b0, cbe_o}, {28'b0, cur.c});
               end
               par_exp = ^{ad_o, cbe_o};
               act = 1'b1; first_dc = 1'b1; idx = 0;
               dcnt = tgt_dly; wcnt = tgt_wait;
            end
         end
      end
   end

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) chk(1'b0, "R9 unexpected word", rd_data, 32'h0);
            else begin
               logic [31:0] e;
               e = exp_q.pop_front();
               chk(rd_data == e, "R9 R12 data word", rd_data, e);
            end
         end
      end
   end

   task automatic do_req(input logic [1:0] k, input logic [31:0] a, input int n,
                         input bit be, input bit df, input bit mm,
                         input int wt, input int dly, input bit nodev, input string tag);
      bit          burst;
      logic [3:0]  cmd;
      logic [31:0] base;
      int          exp_n;
      bit          got_done = 1'b0;
      base  = {a[31:2], 2'b00};
      burst = be && ((k != 2'b01) || df);
      cmd   = (burst && k == 2'b10) ? (mm ? 4'b1100 : 4'b1110) : 4'b0110;
      if (burst) txn_q.push_back('{a: base, c: cmd, len: n});
      else if (nodev) txn_q.push_back('{a: base, c: 4'b0110, len: 1});
      else for (int i = 0; i < n; i++) txn_q.push_back('{a: base + 32'(4 * i), c: 4'b0110, len: 1});
      if (!nodev) begin
         for (int i = 0; i < n; i++) begin
            logic [31:0] w;
            w = memw(base + 32'(4 * i));
            if (i == 0) for (int b = 0; b < 4; b++) if (b < int'(a[1:0])) w[8*b +: 8] = 8'h00;
            exp_q.push_back(w);
         end
      end
      exp_n = nodev ? 1 : (burst ? 1 : n);
      ntxn = 0; tgt_wait = wt; tgt_dly = dly; tgt_nodev = nodev;
      @(negedge clk);
      req_kind = k; req_addr = a; req_words = 8'(n);
      cfg_burst_en = be; cfg_desc_burst = df; cfg_multi_cmd = mm;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      for (int c = 0; c < 3000 && !got_done; c++) begin
         @(negedge clk);
         if (done) begin
            got_done = 1'b1;
            chk(err == nodev, {tag, " R11 error flag"}, {31'b0, err}, {31'b0, nodev});
         end
      end
      chk(got_done, {tag, " done seen"}, {31'b0, got_done}, 32'h1);
      chk(ntxn == exp_n, {tag, " R3 R4 transaction count"}, ntxn, exp_n);
      chk(exp_q.size() == 0 && txn_q.size() == 0, {tag, " R9 queues drained"},
          exp_q.size(), 32'h0);
      exp_q.delete(); txn_q.delete();
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(pci_req_n_o && frame_n_o && irdy_n_o && !ad_oe && !busy && !rd_valid,
          "R6 R13 reset state", {26'b0, pci_req_n_o, frame_n_o, irdy_n_o, ad_oe, busy, rd_valid},
          32'h38);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      do_req(2'b00, 32'h0000_1000, 3, 0, 0, 0, 0, 0, 0, "R1 R3 setup singles");
      do_req(2'b00, 32'h0000_2000, 4, 1, 0, 0, 0, 0, 0, "R1 R3 R8 setup burst");
      do_req(2'b01, 32'h0000_3000, 2, 1, 0, 0, 0, 1, 0, "R4 descriptor no format");
      do_req(2'b01, 32'h0000_3100, 3, 1, 1, 0, 0, 0, 0, "R4 descriptor burst");
      do_req(2'b10, 32'h0000_4000, 4, 1, 0, 0, 2, 2, 0, "R2 R9 line burst waits");
      do_req(2'b10, 32'h0000_5002, 5, 1, 0, 1, 1, 3, 0, "R2 R12 multiple burst");
      do_req(2'b10, 32'h0000_6001, 2, 0, 0, 1, 0, 0, 0, "R2 R12 txbuf singles");
      do_req(2'b10, 32'h0000_7000, 2, 1, 0, 0, 0, 0, 1, "R11 master abort");
      do_req(2'b00, 32'h0000_8003, 1, 1, 0, 0, 3, 0, 0, "R7 R12 after abort");

      // R13: zero word count request is ignored
      @(negedge clk);
      req_kind = 2'b00; req_addr = 32'h0000_9000; req_words = 8'd0; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      begin
         bit quiet = 1'b1;
         for (int c = 0; c < 20; c++) begin
            if (busy || !pci_req_n_o || done) quiet = 1'b0;
            @(negedge clk);
         end
         chk(quiet, "R13 zero count ignored", {31'b0, quiet}, 32'h1);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule